// File: doc/BRIEF.md
# Two-Wire Serial Slave with Extended Register Memory

This block is a two-wire serial slave in front of a 272-byte on-chip register array. The array is laid out as 17 pages of 16 bytes. General-purpose storage sits at 000h–07Fh and a control/status window sits at 080h–08Fh. A first lookup table occupies 090h–0CFh and a second one occupies 0D0h–10Fh. The bus master selects the device with a slave address byte. It then sets a word address and either writes a byte or a burst confined to one page, or reads back a stream that runs across pages. The data line is open-drain: the block only ever pulls it low, and it does so through an output-enable signal.

The word address carried on the bus has only eight bits. The ninth address bit therefore comes from an extension bit held in the control register at 080h. No byte can be changed until software has set a write-enable latch, which sits in the same register. Bus signals are synchronised to the system clock, and START, STOP and both clock edges are detected after synchronisation.

Top module: `twi_regmem`

## Requirements
- R1: A slave address byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal the `strap_i` inputs. Otherwise the slave does not acknowledge, leaves the data line released, and ignores the bus until the next START. Bit 0 selects a read (1) or a write (0).
- R2: Every byte travels most significant bit first, both in and out. A byte written to a general-purpose location reads back unchanged.
- R3: While the write-enable latch is clear, a data byte written to any location other than 080h leaves that location unchanged.
- R4: Register 080h reads as {6'b0, latch, ext}, with the latch in bit 1 and ext in bit 0. Writing 080h always loads bit 1 into the latch. Bit 0 is taken into ext only if the latch was already set before that byte.
- R5: After a matching slave address, every received byte is acknowledged. This includes the word address and data bytes that are discarded.
- R6: In one write transaction the address advances after each data byte. The low four bits wrap within the current 16-byte page, and the upper bits stay fixed.
- R7: In a read, the address advances after each byte across page boundaries. A later read that sends no word address continues from the byte after the last one read.
- R8: Locations 088h–08Fh are reserved: writes to them are dropped and reads return 00h.
- R9: A word-address byte outside 80h–8Fh gets ext as address bit 8, so ext=1 reaches 100h–10Fh. The window 80h–8Fh is reached whatever ext holds. Addresses above 10Fh behave as reserved.
- R10: After reset the latch and ext are clear and every array byte, lookup tables included, reads 00h.
- R11: A START in any state restarts the address phase. This allows a repeated START between setting the word address and reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Device address straps matched against slave address bits 3..1 |
| sda_o | output | 1 | Data value driven when enabled (always 0, open-drain) |
| sda_oe | output | 1 | Pull the data line low when 1 |

## Verification
A write to register 080h can update the write-enable latch and the extension bit on the same serial clock edge. That edge must use the latch value from before the byte, not the one the byte is setting. The bench provokes this by writing 03h to 080h while the latch is clear and expects 02h on read-back. It repeats the write once the latch is set and then expects 03h. A second coincidence occurs on a page write that ends at offset Fh: the store and the wrap of the pointer share one edge. This case is judged by reading the whole page back in a single sequential read.

// File: rtl/twi_regmem.sv
module twi_regmem #(
  parameter logic [3:0] DEV_TYPE   = 4'b1010,
  parameter int         MEM_BYTES  = 272,
  parameter int         PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_o,
  output logic       sda_oe
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] CTRL_A = AW'(128);
  localparam logic [AW-1:0] RSV_LO = AW'(136);
  localparam logic [AW-1:0] RSV_HI = AW'(143);
  localparam logic [AW-1:0] LAST_A = AW'(MEM_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WR, S_RD} st_t;

  st_t           state;
  logic [2:0]    scl_q, sda_q;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txb, rd_data;
  logic [AW-1:0] ptr;
  logic          rw, mnack, wel, ext;
  logic [7:0]    mem [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_h    = scl_q[1];
  wire sda_h    = sda_q[1];
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire dev_ok   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i);
  wire in_rsv   = (ptr >= RSV_LO && ptr <= RSV_HI) || (ptr > LAST_A);
  wire wr_now   = (state == S_WR) && scl_fall && (bitcnt == 4'd8);

  assign sda_o = 1'b0;

  always_comb begin
    if (ptr == CTRL_A)  rd_data = {6'd0, wel, ext};
    else if (in_rsv)    rd_data = 8'h00;
    else                rd_data = mem[ptr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txb    <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mnack  <= 1'b1;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= S_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8 && state != S_RD) shreg <= {shreg[6:0], sda_h};
        if (bitcnt == 4'd8 && state == S_RD) mnack <= sda_h;
        if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          if (state == S_RD) begin
            sda_oe <= 1'b0;
          end else if (state == S_DEV && !dev_ok) begin
            state  <= S_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
          end else begin
            sda_oe <= 1'b1;
            case (state)
              S_DEV:  rw  <= shreg[0];
              S_ADDR: ptr <= (shreg[7:4] == 4'h8) ? AW'({1'b0, shreg}) : AW'({ext, shreg});
              S_WR:   ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
              default: ;
            endcase
          end
        end else if (bitcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          case (state)
            S_DEV:  state <= rw ? S_RD : S_ADDR;
            S_ADDR: state <= S_WR;
            S_RD:   if (mnack) state <= S_IDLE;
            default: ;
          endcase
          if ((state == S_DEV && rw) || (state == S_RD && !mnack)) begin
            txb    <= rd_data;
            sda_oe <= ~rd_data[7];
            ptr    <= ptr + 1'b1;
          end
        end else if (state == S_RD && bitcnt != 4'd0) begin
          sda_oe <= ~txb[3'd7 - bitcnt[2:0]];
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0;
      ext <= 1'b0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
    end else if (wr_now) begin
      if (ptr == CTRL_A) begin
        wel <= shreg[1];
        if (wel) ext <= shreg[0];
      end else if (!in_rsv && wel) begin
        mem[ptr] <= shreg;
      end
    end

endmodule

// File: rtl/twi_regmem_chk.sv
module twi_regmem_chk #(
  parameter int AW = 9,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    scl_q,
  input logic          sda_oe,
  input logic [2:0]    state,
  input logic          wel,
  input logic          ext,
  input logic          wr_now,
  input logic [AW-1:0] ptr
);

  p_drive_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q[1]);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_oe);

  p_wel_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wr_now && ptr == AW'(128)));

  p_ext_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext) |-> $past(wel));

  p_page_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

endmodule

bind twi_regmem twi_regmem_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe), .state(state),
  .wel(wel), .ext(ext), .wr_now(wr_now), .ptr(ptr)
);

// File: tb/twi_regmem_tb_top.sv
module twi_regmem_tb_top;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_o, sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  twi_regmem dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
                    .strap_i(STRAP), .sda_o(sda_o), .sda_oe(sda_oe));

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bstart(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bstop();  sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq(); endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    end
    sda_m = 1; wq(); scl_m = 1; wq(); ack = !sda_bus; wq(); scl_m = 0; wq();
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1; wq(); b = {b[6:0], sda_bus}; wq(); scl_m = 0;
    end
    wq(); sda_m = !mack; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); sda_m = 1;
  endtask

  task automatic wr_burst(input logic [7:0] a, input logic [7:0] d [16], input int n);
    logic ack;
    bstart();
    send(DEVW, ack); chk("R5 dev ack", {7'd0, ack}, 8'h01);
    send(a, ack);    chk("R5 addr ack", {7'd0, ack}, 8'h01);
    for (int i = 0; i < n; i++) begin
      send(d[i], ack); chk("R5 data ack", {7'd0, ack}, 8'h01);
    end
    bstop();
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] d [16];
    d[0] = v;
    wr_burst(a, d, 1);
  endtask

  task automatic rd_burst(input logic [7:0] a, input int n, output logic [7:0] q [16]);
    logic ack;
    bstart(); send(DEVW, ack); send(a, ack);
    bstart(); send(DEVR, ack);
    for (int i = 0; i < n; i++) recv(i != n - 1, q[i]);
    bstop();
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] q [16];
    rd_burst(a, 1, q);
    v = q[0];
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd1(8'h00, v); chk("R10 gp byte", v, 8'h00);
    rd1(8'h80, v); chk("R10 ctrl", v, 8'h00);
    rd1(8'hA7, v); chk("R10 lut1", v, 8'h00);
    rd1(8'hFF, v); chk("R10 lut2", v, 8'h00);
  endtask

  task automatic t_address();
    logic ack;
    bstart(); send({4'b1010, 3'b100, 1'b0}, ack); bstop();
    chk("R1 strap mismatch nack", {7'd0, ack}, 8'h00);
    bstart(); send({4'b1011, STRAP, 1'b0}, ack); bstop();
    chk("R1 type mismatch nack", {7'd0, ack}, 8'h00);
    bstart(); send(DEVW, ack); bstop();
    chk("R1 match ack", {7'd0, ack}, 8'h01);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    wr1(8'h10, 8'hA5);
    rd1(8'h10, v); chk("R3 write while latch clear", v, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    wr1(8'h80, 8'h03);
    rd1(8'h80, v); chk("R4 ext refused while latch clear", v, 8'h02);
    wr1(8'h80, 8'h02);
    rd1(8'h80, v); chk("R4 latch held", v, 8'h02);
  endtask

  task automatic t_byte();
    logic [7:0] v;
    wr1(8'h10, 8'hA5);
    rd1(8'h10, v); chk("R2 byte A5", v, 8'hA5);
    wr1(8'h11, 8'h3C);
    rd1(8'h11, v); chk("R2 byte 3C", v, 8'h3C);
  endtask

  task automatic t_page();
    logic [7:0] d [16];
    logic [7:0] q [16];
    for (int i = 0; i < 8; i++) d[i] = 8'h40 + 8'(i);
    wr_burst(8'h1E, d, 8);
    rd_burst(8'h10, 16, q);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      if (i >= 14) e = 8'h40 + 8'(i - 14);
      else if (i < 6) e = 8'h42 + 8'(i);
      else e = 8'h00;
      chk("R6 page wrap", q[i], e);
    end
  endtask

  task automatic t_seq();
    logic [7:0] q [16];
    logic [7:0] v;
    logic ack;
    wr1(8'h20, 8'h77);
    rd_burst(8'h1E, 4, q);
    chk("R7 seq 1E", q[0], 8'h40);
    chk("R7 seq 1F", q[1], 8'h41);
    chk("R7 seq cross 20", q[2], 8'h77);
    chk("R7 seq 21", q[3], 8'h00);
    rd1(8'h10, v);
    bstart(); send(DEVR, ack); recv(1'b0, v); bstop();
    chk("R7 current address", v, 8'h43);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr1(8'h88, 8'hFF);
    wr1(8'h8F, 8'hFF);
    rd1(8'h88, v); chk("R8 reserved 88", v, 8'h00);
    rd1(8'h8F, v); chk("R8 reserved 8F", v, 8'h00);
    wr1(8'h87, 8'h5A);
    rd1(8'h87, v); chk("R8 neighbour 87", v, 8'h5A);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wr1(8'h80, 8'h03);
    rd1(8'h80, v); chk("R4 ext taken with latch set", v, 8'h03);
    wr1(8'h05, 8'hC3);
    wr1(8'h0F, 8'h99);
    wr1(8'h10, 8'hEE);
    rd1(8'h05, v); chk("R9 byte 105h", v, 8'hC3);
    rd1(8'h0F, v); chk("R9 byte 10Fh", v, 8'h99);
    rd1(8'h10, v); chk("R9 above 10Fh", v, 8'h00);
    wr1(8'h80, 8'h02);
    rd1(8'h05, v); chk("R9 ext clear 005h", v, 8'h00);
    rd1(8'h10, v); chk("R9 ext clear 010h", v, 8'hA5 & 8'h00 | 8'h42);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    logic ack;
    bstart(); send(DEVW, ack); send(8'h21, ack);
    bstart(); send(DEVW, ack);
    chk("R11 restart after address", {7'd0, ack}, 8'h01);
    send(8'h20, ack);
    bstart(); send(DEVR, ack); recv(1'b0, v); bstop();
    chk("R11 repeated start read", v, 8'h77);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 line released", {7'd0, sda_oe}, 8'h00);
    t_reset();
    t_address();
    t_locked();
    t_latch();
    t_byte();
    t_page();
    t_seq();
    t_reserved();
    t_ext();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule